// File: doc/BRIEF.md
# Packed Four-Lane Column Mixer

This block performs the AES column-mixing transform on a 128-bit state of sixteen bytes. It computes the GF(2^8) doubling of the state without a lookup table and without data-dependent branches. One 32-bit word holds four byte lanes, and the block doubles that word in one cycle using word-wide masks, a one-bit shift and a small constant multiply. The four words are doubled over four consecutive cycles. One further cycle combines the doubled and plain bytes into the mixed result, so the latency never depends on the data.

A state enters through a valid/ready input port and the result leaves through a valid/ready output port. The input side takes one state at a time. `in_ready` is high only while the block is idle, so an input offered while a state is in flight is not taken. The output side holds the result until the consumer accepts it with `out_ready`. The block returns to idle on that handshake. A producer may hold `in_valid` high for as long as it likes. A consumer may hold `out_ready` low for as long as it likes, and nothing is lost.

Top module: `colmix_unit`

## Requirements
- R1: Doubling a byte shifts it left by one bit, keeps the low 8 bits, and XORs in 0x1B when bit 7 of the original byte was 1.
- R2: Every byte lane of a word is doubled independently. No bit moves from one lane into the next, and each lane gives the R1 result for all 256 byte values.
- R3: Byte i of the state sits at bits [8i+7:8i] of `in_state` and of `out_state`. Word w covers bytes 4w to 4w+3, and byte 4w is the least significant lane of the word.
- R4: Output byte i equals dbl(x_i) ^ dbl(x_j) ^ x_j ^ x_{(i+8) mod 16} ^ x_{(i+12) mod 16}, where j = (i+4) mod 16 and dbl is the R1 doubling.
- R5: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` falls in the cycle after an accepted input, and it is never high while `out_valid` is high.
- R6: `out_valid` first becomes 1 exactly 5 clock edges after the edge that accepted the input, whatever the data.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_state` does not change. The handshake edge clears `out_valid` and raises `in_ready`.
- R8: `in_valid` asserted while `in_ready` is 0 is ignored. The result that is delivered belongs to the state that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input state offered |
| in_ready | output | 1 | Block idle and able to take a state |
| in_state | input | 128 | Input state, byte i at bits [8i+7:8i] |
| out_valid | output | 1 | Mixed result available |
| out_ready | input | 1 | Consumer takes the result |
| out_state | output | 128 | Mixed result, same byte layout |

## Verification
A wrong word counter or word select corrupts a whole four-byte row of the result. That error is visible on `out_state` when `out_valid` first rises, 5 edges after the input is taken. A fault in the lane masks or in the reduction term shows only for bytes of one value class, for example bytes with the top bit set or bytes that border a lane. For that reason every lane is driven through all 256 byte values. A control fault shows as a shifted `out_valid` edge, as a changed result while the output is stalled, or as a result computed from an input that was offered while the block was busy.

// File: rtl/colmix_pkg.sv
package colmix_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DBL  = 2'd1,
    PH_MIX  = 2'd2,
    PH_OUT  = 2'd3
  } phase_t;
endpackage

// File: rtl/xtime_word.sv
// Branch-free doubling of LANES bytes packed in one word (R1, R2).
module xtime_word #(
  parameter int unsigned LANES = 4,
  parameter logic [7:0]  POLY  = 8'h1B
) (
  input  logic [LANES*8-1:0] word_in,
  output logic [LANES*8-1:0] word_out
);
  localparam int unsigned W = LANES * 8;
  localparam logic [W-1:0] TOP_MASK  = {LANES{8'h80}};
  localparam logic [W-1:0] KEEP_MASK = {LANES{8'hFE}};
  localparam logic [W-1:0] POLY_W    = {{(W-8){1'b0}}, POLY};

  logic [W-1:0] carry_bits;
  logic [W-1:0] reduce;
  logic [W-1:0] shifted;

  always_comb begin
    carry_bits = (word_in & TOP_MASK) >> 7;   // 0 or 1 in each lane
    reduce     = carry_bits * POLY_W;         // POLY per flagged lane, no lane overlap
    shifted    = (word_in << 1) & KEEP_MASK;  // cut the cross-lane carries
    word_out   = shifted ^ reduce;
  end
endmodule

// File: rtl/colmix_combine.sv
// Forms each output byte from doubled and plain bytes (R4).
module colmix_combine #(
  parameter int unsigned LANES = 4,
  parameter int unsigned WORDS = 4
) (
  input  logic [LANES*WORDS*8-1:0] plain,
  input  logic [LANES*WORDS*8-1:0] doubled,
  output logic [LANES*WORDS*8-1:0] mixed
);
  localparam int unsigned NBYTES = LANES * WORDS;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int unsigned J1 = (i + LANES) % NBYTES;
    localparam int unsigned J2 = (i + 2 * LANES) % NBYTES;
    localparam int unsigned J3 = (i + 3 * LANES) % NBYTES;
    assign mixed[i*8 +: 8] = doubled[i*8 +: 8] ^ doubled[J1*8 +: 8] ^ plain[J1*8 +: 8]
                           ^ plain[J2*8 +: 8] ^ plain[J3*8 +: 8];
  end
endmodule

// File: rtl/colmix_ctrl.sv
// Fixed-length sequencer: accept, WORDS doubling cycles, one mix cycle, hold.
module colmix_ctrl #(
  parameter int unsigned WORDS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic accept,
  output logic dbl_en,
  output logic [((WORDS > 1) ? $clog2(WORDS) : 1)-1:0] word_sel,
  output logic mix_en,
  output logic out_valid
);
  import colmix_pkg::*;
  localparam int unsigned CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned LAT   = WORDS + 1;
  localparam int unsigned LAT_W = $clog2(LAT + 2) + 1;

  phase_t            phase_q;
  logic [CNT_W-1:0]  cnt_q;

  assign in_ready  = (phase_q == PH_IDLE);
  assign accept    = in_valid && in_ready;
  assign dbl_en    = (phase_q == PH_DBL);
  assign word_sel  = cnt_q;
  assign mix_en    = (phase_q == PH_MIX);
  assign out_valid = (phase_q == PH_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (in_valid) begin
          phase_q <= PH_DBL;
          cnt_q   <= '0;
        end
        PH_DBL: begin
          if (cnt_q == CNT_W'(WORDS - 1)) phase_q <= PH_MIX;
          else                            cnt_q   <= cnt_q + 1'b1;
        end
        PH_MIX:  phase_q <= PH_OUT;
        PH_OUT:  if (out_ready) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // Edge counter since the last accept, used only by the latency check.
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lat_q <= '0;
    else if (accept)                     lat_q <= '0;
    else if (!in_ready && !out_valid)    lat_q <= lat_q + 1'b1;
  end

  assert_fixed_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q == LAT_W'(LAT));

  assert_ready_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

// File: rtl/colmix_unit.sv
module colmix_unit #(
  parameter int unsigned LANES = 4,
  parameter int unsigned WORDS = 4,
  parameter logic [7:0]  POLY  = 8'h1B
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANES*WORDS*8-1:0] in_state,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*WORDS*8-1:0] out_state
);
  localparam int unsigned WORD_W  = LANES * 8;
  localparam int unsigned STATE_W = WORD_W * WORDS;
  localparam int unsigned CNT_W   = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic              accept, dbl_en, mix_en;
  logic [CNT_W-1:0]  word_sel;
  logic [STATE_W-1:0] state_q, dbl_q, mixed, result_q;
  logic [WORD_W-1:0]  st_words [WORDS];
  logic [WORD_W-1:0]  cur_word, cur_dbl;

  colmix_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .accept(accept), .dbl_en(dbl_en), .word_sel(word_sel),
    .mix_en(mix_en), .out_valid(out_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= '0;
    else if (accept) state_q <= in_state;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign st_words[w] = state_q[w*WORD_W +: WORD_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    dbl_q[w*WORD_W +: WORD_W] <= '0;
      else if (dbl_en && word_sel == CNT_W'(w))      dbl_q[w*WORD_W +: WORD_W] <= cur_dbl;
    end
  end

  assign cur_word = st_words[word_sel];

  xtime_word #(.LANES(LANES), .POLY(POLY)) u_xt (
    .word_in(cur_word), .word_out(cur_dbl)
  );

  colmix_combine #(.LANES(LANES), .WORDS(WORDS)) u_mix (
    .plain(state_q), .doubled(dbl_q), .mixed(mixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (mix_en) result_q <= mixed;
  end

  assign out_state = result_q;

  assert_output_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_state)));

  assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(state_q));
endmodule

// File: tb/sim_colmix_unit.sv
module sim_colmix_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [127:0] in_state, out_state;
  int checks = 0, errors = 0, cycles = 0;

  colmix_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_state(in_state), .out_valid(out_valid), .out_ready(out_ready),
    .out_state(out_state)
  );

  // Published column vectors placed four columns wide (R3 layout).
  localparam int NV = 3;
  localparam logic [127:0] VEC_IN [NV] = '{
    128'hc6015c45_c6012253_c6010a13_c601f2db,
    128'hff004cd5_ff0031d4_ff0026d4_ff002dd4,
    128'h0
  };
  localparam logic [127:0] VEC_EXP [NV] = '{
    128'hc6019dbc_c60158a1_c601dc4d_c6019f8e,
    128'hff00f8d6_ff00bdd7_ff007ed5_ff004dd5,
    128'h0
  };

  function automatic logic [7:0] ref_dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [127:0] ref_mix(input logic [127:0] s);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      r[i*8 +: 8] = ref_dbl(s[i*8 +: 8]) ^ ref_dbl(s[((i+4)%16)*8 +: 8]) ^ s[((i+4)%16)*8 +: 8]
                  ^ s[((i+8)%16)*8 +: 8] ^ s[((i+12)%16)*8 +: 8];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  // One transaction; junk keeps in_valid high with other data while busy (R8).
  task automatic xact(input logic [127:0] din, input logic [127:0] exp,
                      input string tag, input bit junk, input bit full);
    int k;
    @(negedge clk); in_valid = 1'b1; in_state = din;
    @(negedge clk);
    if (junk) in_state = ~din; else in_valid = 1'b0;
    if (full) chk({tag, " R5 in_ready low after accept"}, {127'h0, in_ready}, 128'h0);
    k = 0;
    while (!out_valid && k < 20) begin @(negedge clk); k++; end
    chk({tag, " R6 latency"}, 128'(k), 128'd5);
    chk({tag, " R4 data"}, out_state, exp);
    if (full) begin
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk({tag, " R7 held valid"}, {127'h0, out_valid}, 128'h1);
      chk({tag, " R7 held data"}, out_state, exp);
      chk({tag, " R5 no overlap"}, {127'h0, in_ready}, 128'h0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    if (full) begin
      chk({tag, " R7 valid cleared"}, {127'h0, out_valid}, 128'h0);
      chk({tag, " R7 ready back"}, {127'h0, in_ready}, 128'h1);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_state = '0;
    repeat (3) @(negedge clk);
    chk("R5 reset in_ready", {127'h0, in_ready}, 128'h1);
    chk("R5 reset out_valid", {127'h0, out_valid}, 128'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) xact(VEC_IN[v], VEC_EXP[v], "R4 vector table", 1'b0, 1'b1);

    // R8: other data offered during busy must not replace the accepted state.
    xact(VEC_IN[0], VEC_EXP[0], "R8 busy offer ignored", 1'b1, 1'b1);

    // R1 R2 R3: single byte per position exposes the doubling of that lane.
    for (int j = 0; j < 16; j += 5) begin
      logic [127:0] s;
      s = '0; s[j*8 +: 8] = 8'h80;
      xact(s, ref_mix(s), "R1 R3 single top-bit byte", 1'b0, 1'b0);
    end

    // R2: every lane of every word sees all 256 byte values.
    for (int v = 0; v < 256; v++) begin
      logic [127:0] s;
      for (int j = 0; j < 16; j++) s[j*8 +: 8] = 8'(v + 37 * j);
      xact(s, ref_mix(s), "R2 lane sweep", 1'b0, 1'b0);
    end

    finish_run();
  end
endmodule